// File: doc/BRIEF.md
# Prefix-Activated Bank Address Extender

This block sits beside an 8-bit processor with a 16-bit address bus and widens every bus cycle's address to 24 bits. It watches the bus only (opcode-fetch strobe, read/write, address and data) and drives the upper eight address bits, so memory behind it sees up to 256 windows of 64 KB each. The processor is unaware of the block: two of its spare no-operation opcodes are given a meaning by the watcher.

One of them, the bank-load opcode, is a two-byte, four-cycle instruction. The byte read on its last cycle is stored in an 8-bit bank register. The other, the prefix opcode, is a one-byte, one-cycle instruction. It arms the block so that the data access of the instruction right after it goes out with the bank register as address bits 23 to 16. Every other cycle, including operand and pointer fetches of that same prefixed instruction, goes out in bank zero. Software can therefore reach any byte of a 16 MB space with a bank-load, a prefix and an ordinary indirect load: 4 + 1 + 6 = 11 cycles.

All state advances on the falling clock edge, which ends a bus cycle. The upper address bits are a combinational function of the current strobe and the stored state.

Top module: `bankx_prefix_ext`

## Requirements
- R1: On every cycle, addr_ext[15:0] equals addr.
- R2: On every opcode-fetch cycle (sync high), and on every cycle of an instruction that has no prefix before it, addr_ext[23:16] is 0.
- R3: An instruction with opcode 0xD4 loads the bank register with the data byte of its fourth cycle, taken at the falling edge that ends that cycle, provided that cycle is a read (rw high) with sync low. The bank register changes at no other time.
- R4: Opcode 0x0B is a one-cycle prefix. It affects only the instruction whose opcode fetch comes right after it. The next instruction after that goes out in bank zero again.
- R5: In a prefixed instruction with opcode bits [1:0] = 01, the data access cycle carries the bank register on addr_ext[23:16]. Counting the opcode fetch as cycle 1, that cycle is selected by opcode bits [4:2]: 000 (zero-page,X indirect) gives cycle 6, 001 (zero page) gives cycle 3, 011 (absolute) gives cycle 4, and 101 (zero-page,X) gives cycle 4. This holds for reads and for writes.
- R6: Operand-fetch, dummy and pointer-fetch cycles of a prefixed instruction go out in bank zero.
- R7: A prefixed instruction whose opcode falls outside the R5 set, such as immediate 0xA9, never carries the bank. The prefix is still used up by that instruction.
- R8: While reset is asserted, addr_ext[23:16] is 0. After reset, the bank register is 0 and no prefix is pending.
- R9: A prefix that directly follows a prefix keeps the arming. The bank then goes to the first instruction that is not a prefix.
- R10: If the fourth cycle of a 0xD4 instruction is a write (rw low), the bank register keeps its previous value.
- R11: The sequence bank-load, prefix, zero-page,X indirect load takes 11 cycles, and only cycle 11 carries the loaded bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; its falling edge ends a bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | High during an opcode-fetch cycle |
| rw | input | 1 | High for a read cycle, low for a write |
| addr | input | 16 | Processor address |
| data | input | 8 | Processor data bus, valid at the end of the cycle |
| addr_ext | output | 24 | Extended address: bank bits over the processor address |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit bank, prefix opcode 0x0B, bank-load opcode 0xD4 and a bank-load capture on cycle 4. These values let the bench drive real instruction streams cycle by cycle: zero-page, absolute, zero-page,X, both directions of the indirect mode, immediate operands, back-to-back prefixes, a bank-load whose last cycle is a write, and a reset in the middle of an armed sequence. The extreme bank values 0x00 and 0xFF are both used.

// File: rtl/bankx_pkg.sv
package bankx_pkg;

  // Instruction cycle index; 0 means no instruction seen since reset.
  localparam int unsigned CYC_MAX = 7;
  localparam int unsigned CYC_W   = $clog2(CYC_MAX + 1);

  typedef logic [CYC_W-1:0] cyc_t;

  // Cycle index (opcode fetch = 1) of the data access for the addressing
  // modes that take a bank; 0 when the opcode takes none.
  function automatic cyc_t data_cycle(input logic [7:0] op);
    cyc_t r;
    r = '0;
    if (op[1:0] == 2'b01) begin
      case (op[4:2])
        3'b000:  r = cyc_t'(6);
        3'b001:  r = cyc_t'(3);
        3'b011:  r = cyc_t'(4);
        3'b101:  r = cyc_t'(4);
        default: r = '0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/bankx_rst_sync.sv
module bankx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [1:0] stage_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_ns = stage_q[1];

endmodule

// File: rtl/bankx_seq_tracker.sv
module bankx_seq_tracker
  import bankx_pkg::*;
#(
  parameter logic [7:0] PREFIX_OP = 8'h0B,
  parameter logic [7:0] RESET_OP  = 8'hEA
) (
  input  logic       clk,
  input  logic       rst_ns,
  input  logic       sync,
  input  logic [7:0] data,
  output logic [7:0] op_q,
  output cyc_t       cyc_q,
  output logic       live_q
);

  logic [7:0] op_d;
  cyc_t       cyc_d;
  logic       pend_q, pend_d;
  logic       live_d;
  logic       is_prefix;

  assign is_prefix = (data == PREFIX_OP);

  always_comb begin
    op_d   = op_q;
    cyc_d  = cyc_q;
    pend_d = pend_q;
    live_d = live_q;
    if (sync) begin
      op_d   = data;
      cyc_d  = cyc_t'(2);
      pend_d = is_prefix;
      live_d = pend_q && !is_prefix;
    end else if (cyc_q != '0 && cyc_q != cyc_t'(CYC_MAX)) begin
      cyc_d = cyc_q + cyc_t'(1);
    end
  end

  always_ff @(negedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      op_q   <= RESET_OP;
      cyc_q  <= '0;
      pend_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      op_q   <= op_d;
      cyc_q  <= cyc_d;
      pend_q <= pend_d;
      live_q <= live_d;
    end
  end

endmodule

// File: rtl/bankx_bank_reg.sv
module bankx_bank_reg
  import bankx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BANK_W   = 8,
  parameter logic [7:0]  LOAD_OP  = 8'hD4,
  parameter int unsigned LOAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              sync,
  input  logic              rw,
  input  logic [DATA_W-1:0] data,
  input  logic [7:0]        op_q,
  input  cyc_t              cyc_q,
  output logic [BANK_W-1:0] bank_q
);

  logic              cap_en;
  logic [BANK_W-1:0] bank_d;

  assign cap_en = !sync && rw && (op_q == LOAD_OP) && (cyc_q == cyc_t'(LOAD_CYC));

  always_comb begin
    bank_d = bank_q;
    if (cap_en) bank_d = data[BANK_W-1:0];
  end

  always_ff @(negedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      bank_q <= '0;
    end else begin
      bank_q <= bank_d;
    end
  end

endmodule

// File: rtl/bankx_hi_mux.sv
module bankx_hi_mux
  import bankx_pkg::*;
#(
  parameter int unsigned BANK_W = 8
) (
  input  logic              sync,
  input  logic              live_q,
  input  logic [7:0]        op_q,
  input  cyc_t              cyc_q,
  input  logic [BANK_W-1:0] bank_q,
  output logic [BANK_W-1:0] hi
);

  cyc_t dcyc;
  logic apply;

  assign dcyc  = data_cycle(op_q);
  assign apply = !sync && live_q && (dcyc != '0) && (cyc_q == dcyc);
  assign hi    = apply ? bank_q : '0;

endmodule

// File: rtl/bankx_prefix_ext.sv
module bankx_prefix_ext
  import bankx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BANK_W    = 8,
  parameter logic [7:0]  PREFIX_OP = 8'h0B,
  parameter logic [7:0]  LOAD_OP   = 8'hD4,
  parameter int unsigned LOAD_CYC  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync,
  input  logic                     rw,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        data,
  output logic [ADDR_W+BANK_W-1:0] addr_ext
);

  localparam int unsigned EXT_W = ADDR_W + BANK_W;

  logic              rst_ns;
  logic [7:0]        op_q;
  cyc_t              cyc_q;
  logic              live_q;
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] hi;

  bankx_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  bankx_seq_tracker #(
    .PREFIX_OP (PREFIX_OP)
  ) u_trk (
    .clk    (clk),
    .rst_ns (rst_ns),
    .sync   (sync),
    .data   (data[7:0]),
    .op_q   (op_q),
    .cyc_q  (cyc_q),
    .live_q (live_q)
  );

  bankx_bank_reg #(
    .DATA_W   (DATA_W),
    .BANK_W   (BANK_W),
    .LOAD_OP  (LOAD_OP),
    .LOAD_CYC (LOAD_CYC)
  ) u_bank (
    .clk    (clk),
    .rst_ns (rst_ns),
    .sync   (sync),
    .rw     (rw),
    .data   (data),
    .op_q   (op_q),
    .cyc_q  (cyc_q),
    .bank_q (bank_q)
  );

  bankx_hi_mux #(
    .BANK_W (BANK_W)
  ) u_mux (
    .sync   (sync),
    .live_q (live_q),
    .op_q   (op_q),
    .cyc_q  (cyc_q),
    .bank_q (bank_q),
    .hi     (hi)
  );

  assign addr_ext = EXT_W'({hi, addr});

endmodule

// File: rtl/bankx_prefix_ext_chk.sv
module bankx_prefix_ext_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BANK_W = 8
) (
  input logic                     clk,
  input logic                     rst_ns,
  input logic                     sync,
  input logic                     rw,
  input logic [ADDR_W-1:0]        addr,
  input logic [ADDR_W+BANK_W-1:0] addr_ext,
  input logic [BANK_W-1:0]        bank_q
);

  localparam int unsigned EXT_W = ADDR_W + BANK_W;

  logic [BANK_W-1:0] hi_s;
  assign hi_s = addr_ext[EXT_W-1:ADDR_W];

  // R1: the processor address passes through untouched
  assert_low_pass_R1: assert property (@(negedge clk) disable iff (!rst_ns)
    addr_ext[ADDR_W-1:0] == addr);

  // R2: opcode fetches always go out in bank zero
  assert_fetch_bank0_R2: assert property (@(negedge clk) disable iff (!rst_ns)
    sync |-> hi_s == '0);

  // R3: the bank only changes after a read cycle that is not a fetch
  assert_bank_load_R3: assert property (@(negedge clk) disable iff (!rst_ns)
    !$stable(bank_q) |-> $past(rw && !sync));

  // R4: the bank is applied on one isolated cycle at a time
  assert_single_access_R4: assert property (@(negedge clk) disable iff (!rst_ns)
    (hi_s != '0) |=> (hi_s == '0));

  // R5: any non-zero upper bits are the bank register
  assert_hi_is_bank_R5: assert property (@(negedge clk) disable iff (!rst_ns)
    (hi_s != '0) |-> (hi_s == bank_q));

endmodule

bind bankx_prefix_ext bankx_prefix_ext_chk #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W)
) u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .sync     (sync),
  .rw       (rw),
  .addr     (addr),
  .addr_ext (addr_ext),
  .bank_q   (bank_q)
);

// File: tb/bankx_prefix_ext_bench.sv
module bankx_prefix_ext_bench;

  logic        clk;
  logic        rst_n;
  logic        sync;
  logic        rw;
  logic [15:0] addr;
  logic [7:0]  data;
  logic [23:0] addr_ext;

  int unsigned vectors;
  int unsigned misses;

  // behavioural model state
  logic [7:0] bank_m;
  bit         pend_m;

  bankx_prefix_ext u_bankx_prefix_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync     (sync),
    .rw       (rw),
    .addr     (addr),
    .data     (data),
    .addr_ext (addr_ext)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // one bus cycle: drive after the rising edge, compare before the falling edge
  task automatic bc(input bit s, input bit r, input logic [15:0] a,
                    input logic [7:0] d, input logic [7:0] eh, input string tag);
    @(posedge clk);
    sync = s; rw = r; addr = a; data = d;
    #2;
    vectors++;
    if (addr_ext !== {eh, a}) begin
      misses++;
      $display("FAIL %s: addr_ext=%h expected=%h", tag, addr_ext, {eh, a});
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) bc(1'b0, 1'b1, 16'hFFF0, 8'h00, 8'h00, tag);
  endtask

  function automatic logic [7:0] take_bank();
    logic [7:0] b;
    b = pend_m ? bank_m : 8'h00;
    pend_m = 1'b0;
    return b;
  endfunction

  task automatic t_prefix(input logic [15:0] pc);
    bc(1'b1, 1'b1, pc, 8'h0B, 8'h00, "R4");
    pend_m = 1'b1;
  endtask

  task automatic t_ldb(input logic [15:0] pc, input logic [7:0] zp, input logic [7:0] x,
                       input logic [7:0] b, input bit last_rd);
    logic [7:0] ea;
    ea = zp + x;
    pend_m = 1'b0;
    bc(1'b1, 1'b1, pc, 8'hD4, 8'h00, "R3");
    bc(1'b0, 1'b1, pc + 16'd1, zp, 8'h00, "R3");
    bc(1'b0, 1'b1, {8'h00, zp}, 8'h3C, 8'h00, "R3");
    bc(1'b0, last_rd, {8'h00, ea}, b, 8'h00, last_rd ? "R3" : "R10");
    if (last_rd) bank_m = b;
  endtask

  // zero-page,X indirect: 0xA1 read, 0x81 write; data on cycle 6
  task automatic t_ind(input logic [15:0] pc, input logic [7:0] op, input logic [7:0] zp,
                       input logic [7:0] x, input logic [15:0] ptr, input string tag);
    logic [7:0] eh, p0;
    eh = take_bank();
    p0 = zp + x;
    bc(1'b1, 1'b1, pc, op, 8'h00, "R2");
    bc(1'b0, 1'b1, pc + 16'd1, zp, 8'h00, "R6");
    bc(1'b0, 1'b1, {8'h00, zp}, 8'h11, 8'h00, "R6");
    bc(1'b0, 1'b1, {8'h00, p0}, ptr[7:0], 8'h00, "R6");
    bc(1'b0, 1'b1, {8'h00, 8'(p0 + 8'd1)}, ptr[15:8], 8'h00, "R6");
    bc(1'b0, (op != 8'h81), ptr, 8'h99, eh, tag);
  endtask

  // zero page: 0xA5 read, 0x85 write; data on cycle 3
  task automatic t_zp(input logic [15:0] pc, input logic [7:0] op, input logic [7:0] zp);
    logic [7:0] eh;
    eh = take_bank();
    bc(1'b1, 1'b1, pc, op, 8'h00, "R2");
    bc(1'b0, 1'b1, pc + 16'd1, zp, 8'h00, "R6");
    bc(1'b0, (op != 8'h85), {8'h00, zp}, 8'h42, eh, "R5");
  endtask

  // absolute read 0xAD; data on cycle 4
  task automatic t_abs(input logic [15:0] pc, input logic [15:0] a, input string tag);
    logic [7:0] eh;
    eh = take_bank();
    bc(1'b1, 1'b1, pc, 8'hAD, 8'h00, "R2");
    bc(1'b0, 1'b1, pc + 16'd1, a[7:0], 8'h00, "R6");
    bc(1'b0, 1'b1, pc + 16'd2, a[15:8], 8'h00, "R6");
    bc(1'b0, 1'b1, a, 8'h24, eh, tag);
  endtask

  // zero-page,X read 0xB5; data on cycle 4
  task automatic t_zpx(input logic [15:0] pc, input logic [7:0] zp, input logic [7:0] x);
    logic [7:0] eh, ea;
    eh = take_bank();
    ea = zp + x;
    bc(1'b1, 1'b1, pc, 8'hB5, 8'h00, "R2");
    bc(1'b0, 1'b1, pc + 16'd1, zp, 8'h00, "R6");
    bc(1'b0, 1'b1, {8'h00, zp}, 8'h00, 8'h00, "R6");
    bc(1'b0, 1'b1, {8'h00, ea}, 8'h66, eh, "R5");
  endtask

  // immediate 0xA9: no data access, bank never applied
  task automatic t_imm(input logic [15:0] pc);
    void'(take_bank());
    bc(1'b1, 1'b1, pc, 8'hA9, 8'h00, "R7");
    bc(1'b0, 1'b1, pc + 16'd1, 8'h77, 8'h00, "R7");
  endtask

  initial begin
    #2_000_000;
    misses++;
    vectors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    vectors = 0; misses = 0;
    bank_m = 8'h00; pend_m = 1'b0;
    rst_n = 1'b0; sync = 1'b0; rw = 1'b1; addr = 16'h0000; data = 8'h00;

    // R8: opcodes seen during reset leave no trace
    bc(1'b1, 1'b1, 16'h0200, 8'h0B, 8'h00, "R8");
    bc(1'b1, 1'b1, 16'h0201, 8'hD4, 8'h00, "R8");
    bc(1'b0, 1'b1, 16'h0202, 8'h10, 8'h00, "R8");
    bc(1'b0, 1'b1, 16'h0010, 8'hAB, 8'h00, "R8");
    @(posedge clk); rst_n = 1'b1;
    idle(3, "R1");

    t_zp(16'h0300, 8'hA5, 8'h20);                          // R2 unprefixed
    t_abs(16'h0302, 16'h8000, "R2");

    // R11: bank-load, prefix, indirect load = 11 cycles, bank on the last
    t_ldb(16'h0400, 8'h30, 8'h02, 8'h12, 1'b1);
    t_prefix(16'h0402);
    t_ind(16'h0403, 8'hA1, 8'h40, 8'h04, 16'h1234, "R11");
    t_abs(16'h0405, 16'h9000, "R4");                       // R4: prefix used up

    t_prefix(16'h0500); t_zp(16'h0501, 8'h85, 8'h50);      // R5 zero-page write
    t_prefix(16'h0503); t_abs(16'h0504, 16'hC0DE, "R5");   // R5 absolute
    t_prefix(16'h0507); t_zpx(16'h0508, 8'hF0, 8'h20);     // R5 zero-page,X wrap

    t_prefix(16'h0600); t_imm(16'h0601);                   // R7 immediate
    t_abs(16'h0603, 16'h4000, "R7");

    t_prefix(16'h0700); t_prefix(16'h0701);                // R9 double prefix
    t_abs(16'h0702, 16'hBEEF, "R9");

    t_ldb(16'h0800, 8'h60, 8'h01, 8'h77, 1'b0);            // R10 write, no capture
    t_prefix(16'h0802); t_abs(16'h0803, 16'h2222, "R10");

    t_ldb(16'h0900, 8'h70, 8'hFF, 8'hFF, 1'b1);            // bank 0xFF
    t_prefix(16'h0902);
    t_ind(16'h0903, 8'h81, 8'hFE, 8'h01, 16'hFFFF, "R5");  // indirect write
    t_ldb(16'h0910, 8'h70, 8'h00, 8'h00, 1'b1);            // bank 0x00
    t_prefix(16'h0912); t_abs(16'h0913, 16'h1111, "R3");

    // R8: reset in the middle of an armed sequence
    t_ldb(16'h0A00, 8'h10, 8'h00, 8'h5A, 1'b1);
    t_prefix(16'h0A02);
    @(posedge clk); rst_n = 1'b0;
    bank_m = 8'h00; pend_m = 1'b0;
    idle(2, "R8");
    @(posedge clk); rst_n = 1'b1;
    idle(3, "R8");
    t_abs(16'h0A03, 16'h3333, "R8");
    t_prefix(16'h0A06); t_abs(16'h0A07, 16'h3334, "R8");

    idle(2, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule